// File: doc/BRIEF.md
# Write-Hit Policy Controller for a Direct-Mapped Data Cache

This block decides what happens when the processor stores into a small direct-mapped data cache. Every line holds four 32-bit words, an address tag, a valid flag and a modified flag. Each store arrives with a region attribute that selects one of two policies. Under write-through, a hit merges the stored bytes into the line, sends the same store to external memory, and stalls the processor until memory acknowledges it. Under copyback, a hit merges the bytes, marks the line modified and completes in the same cycle, with no bus traffic.

A store that misses is forwarded to memory as is and allocates nothing. A store whose size and low address bits do not form an aligned access is rejected with an error. Lines are installed through a fill port, which stands for the refill path that lies outside this block. A probe port reads any word together with its hit and modified flags. The array update strobe is also exported so that neighbouring logic can follow each merge.

Top module: `wpdc_ctrl`

## Requirements
- R1: Size code 00 is one byte, 01 is 16 bits and 10 is 32 bits. Store data is right-justified, and byte offset k (address bits 1:0) maps to data bits 8k+7:8k. On a hit, only the bytes selected by size and offset change, in the word chosen by address bits 3:2 of the line chosen by bits 7:4.
- R2: A write-through hit raises mem_req one cycle after it is accepted. It presents the full byte address, the byte enables and the lane-placed data, holds them until mem_ack, and raises req_done in the cycle mem_ack is high.
- R3: A write-through hit leaves the line's modified flag unchanged, whether that flag was 0 or 1.
- R4: A copyback hit raises req_done, upd_en and upd_set_mod in its request cycle. It never raises mem_req, and afterwards the line reads as modified.
- R5: A copyback hit on a line that is already modified merges its bytes, and the line stays modified.
- R6: A miss in either region changes no line and allocates nothing. It is sent to memory exactly as a write-through hit is, and completes on mem_ack.
- R7: A 16-bit store with address bit 0 set, a 32-bit store with address bits 1:0 nonzero, or size code 11 gives req_done with req_err in the request cycle. Such a store causes no array update and no memory request.
- R8: A fill installs all four words, sets valid and clears modified. A store presented in the same cycle as a fill waits: it gets no req_done and no update in that cycle, and is served afterwards against the filled contents.
- R9: After reset, no line is valid, and mem_req, req_done and req_err are low.
- R10: mem_ack while no memory write is pending has no effect. No req_done is given and no line changes.
- R11: probe_hit, probe_mod and probe_data show, combinationally, the state of the word at probe_addr. probe_addr is a word address, and its bits 1:0 select the word within the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Store request, held until req_done |
| req_addr | input | 32 | Store byte address |
| req_size | input | 2 | Access size code |
| req_data | input | 32 | Right-justified store data |
| req_copyback | input | 1 | Region policy: 1 copyback, 0 write-through |
| req_done | output | 1 | Store completes this cycle |
| req_err | output | 1 | Store rejected as misaligned |
| mem_req | output | 1 | External write pending |
| mem_addr | output | 32 | External write byte address |
| mem_be | output | 4 | External write byte enables |
| mem_data | output | 32 | External write data, lane-placed |
| mem_ack | input | 1 | External write acknowledge |
| fill_valid | input | 1 | Install a line this cycle |
| fill_line_addr | input | 28 | Line address of the install |
| fill_data | input | 128 | Four words, word 0 in the low bits |
| probe_addr | input | 30 | Word address to observe |
| probe_hit | output | 1 | Probed word is present |
| probe_mod | output | 1 | Probed line is modified |
| probe_data | output | 32 | Probed word |
| upd_en | output | 1 | Array merge this cycle |
| upd_index | output | 4 | Line index of the merge |
| upd_word | output | 2 | Word of the merge |
| upd_be | output | 4 | Byte enables of the merge |
| upd_data | output | 32 | Lane-placed merge data |
| upd_set_mod | output | 1 | Merge also sets the modified flag |

## Verification
A line install and a store can arrive in the same cycle, and can target the same line. The bench provokes this by driving fill_valid together with a copyback store to the line being refilled. It expects no completion and no merge in that cycle, then a merge on top of the new fill data and a line that ends modified. A behavioural model of tags, flags and words is compared with the probe port on every clock. Each store also checks the completion cycle and the memory request fields.

// File: rtl/wpdc_pkg.sv
// Package: shared encodings for the write-policy cache controller.
// Assumes a 2-bit size code and a two-state store sequencer.
package wpdc_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } wr_state_e;
endpackage

// File: rtl/wpdc_lanes.sv
// Module: wpdc_lanes
// Turns size and byte offset into byte enables and places right-justified
// store data on its byte lanes (offset k -> lane k). Flags misaligned or
// reserved sizes. Assumes BYTES is a power of two and at least 4.
module wpdc_lanes #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  offs,
    input  logic [DATA_W-1:0] data,
    output logic [BYTES-1:0]  be,
    output logic [DATA_W-1:0] lane_data,
    output logic              bad
);
    import wpdc_pkg::*;

    int nb;

    // Decode access width, alignment and the enabled lanes.
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: nb = 1;
            SZ_HALF: nb = 2;
            SZ_LONG: nb = BYTES;
            default: nb = 0;
        endcase
        bad = (nb == 0) || ((int'(offs) & (nb - 1)) != 0);
        for (int b = 0; b < BYTES; b++) begin
            be[b] = !bad && (b >= int'(offs)) && (b < int'(offs) + nb);
        end
    end

    // Shift the store data onto its lanes.
    always_comb lane_data = data << {offs, 3'b000};
endmodule

// File: rtl/wpdc_store.sv
// Module: wpdc_store
// Direct-mapped line storage: tags, valid and modified flags, and word data.
// One lookup port, one probe port, one byte-masked word write, one full-line
// install. Assumes the caller never asserts wr_en and fill_en together.
module wpdc_store #(
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 24,
    localparam int BYTES = DATA_W / 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        lk_idx,
    input  logic [TAG_W-1:0]        lk_tag,
    output logic                    lk_hit,
    input  logic [IDX_W-1:0]        pr_idx,
    input  logic [TAG_W-1:0]        pr_tag,
    input  logic [WSEL_W-1:0]       pr_word,
    output logic                    pr_hit,
    output logic                    pr_mod,
    output logic [DATA_W-1:0]       pr_data,
    input  logic                    wr_en,
    input  logic                    wr_set_mod,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WSEL_W-1:0]       wr_word,
    input  logic [BYTES-1:0]        wr_be,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    fill_en,
    input  logic [IDX_W-1:0]        fill_idx,
    input  logic [TAG_W-1:0]        fill_tag,
    input  logic [WORDS*DATA_W-1:0] fill_data
);
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  mod_q;
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES][WORDS];

    // Line flags: cleared by reset, set by install, modified set by copyback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            mod_q   <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
            mod_q[fill_idx]   <= 1'b0;
        end else if (wr_en && wr_set_mod) begin
            mod_q[wr_idx] <= 1'b1;
        end
    end

    // Tag capture on install.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx] <= fill_tag;
    end

    // Word data per word slot: whole-line install or byte-masked merge.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (fill_en) begin
                dat_q[fill_idx][w] <= fill_data[w*DATA_W +: DATA_W];
            end else if (wr_en && (wr_word == WSEL_W'(w))) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (wr_be[b]) dat_q[wr_idx][w][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    // Hit detection for the store path.
    always_comb lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

    // Observation path.
    always_comb begin
        pr_hit  = valid_q[pr_idx] && (tag_q[pr_idx] == pr_tag);
        pr_mod  = mod_q[pr_idx];
        pr_data = dat_q[pr_idx][pr_word];
    end
endmodule

// File: rtl/wpdc_seq.sv
// Module: wpdc_seq
// Store sequencer. In idle it classifies a request as error, copyback hit,
// write-through hit or miss; the last two wait for the memory acknowledge.
// A line install in the same cycle defers the request. Assumes req_valid
// is held until req_done.
module wpdc_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic fill_busy,
    input  logic bad,
    input  logic hit,
    input  logic copyback,
    input  logic mem_ack,
    output logic upd_en,
    output logic set_mod,
    output logic load_mem,
    output logic req_done,
    output logic req_err,
    output logic mem_req
);
    import wpdc_pkg::*;

    wr_state_e state_q, state_d;
    logic      go;

    // Classify the request and produce the per-cycle strobes.
    always_comb begin
        go       = (state_q == ST_IDLE) && req_valid && !fill_busy;
        req_err  = go && bad;
        upd_en   = go && !bad && hit;
        set_mod  = upd_en && copyback;
        load_mem = go && !bad && !(hit && copyback);
        req_done = req_err || set_mod || ((state_q == ST_WAIT) && mem_ack);
        mem_req  = (state_q == ST_WAIT);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (load_mem) state_d = ST_WAIT;
            ST_WAIT: if (mem_ack)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/wpdc_ctrl.sv
// Module: wpdc_ctrl (top)
// Write-hit controller of a direct-mapped data cache with per-access
// write-through or copyback policy. Splits the address, forms lanes,
// looks up the line, sequences the store and holds the outgoing memory
// write. Assumes 32-bit words and req_valid held until req_done.
module wpdc_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - OFF_W,
    localparam int LINE_W = ADDR_W - WSEL_W - OFF_W,
    localparam int WADR_W = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic [DATA_W-1:0]       req_data,
    input  logic                    req_copyback,
    output logic                    req_done,
    output logic                    req_err,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BYTES-1:0]        mem_be,
    output logic [DATA_W-1:0]       mem_data,
    input  logic                    mem_ack,
    input  logic                    fill_valid,
    input  logic [LINE_W-1:0]       fill_line_addr,
    input  logic [WORDS*DATA_W-1:0] fill_data,
    input  logic [WADR_W-1:0]       probe_addr,
    output logic                    probe_hit,
    output logic                    probe_mod,
    output logic [DATA_W-1:0]       probe_data,
    output logic                    upd_en,
    output logic [IDX_W-1:0]        upd_index,
    output logic [WSEL_W-1:0]       upd_word,
    output logic [BYTES-1:0]        upd_be,
    output logic [DATA_W-1:0]       upd_data,
    output logic                    upd_set_mod
);
    logic [OFF_W-1:0]  r_off;
    logic [WSEL_W-1:0] r_word;
    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;
    logic [BYTES-1:0]  lane_be;
    logic [DATA_W-1:0] lane_data;
    logic              lane_bad;
    logic              hit;
    logic              load_mem;
    logic [ADDR_W-1:0] mem_addr_q;
    logic [BYTES-1:0]  mem_be_q;
    logic [DATA_W-1:0] mem_data_q;

    // Address split of the store.
    always_comb begin
        r_off  = req_addr[OFF_W-1:0];
        r_word = req_addr[OFF_W +: WSEL_W];
        r_idx  = req_addr[OFF_W+WSEL_W +: IDX_W];
        r_tag  = req_addr[ADDR_W-1 -: TAG_W];
    end

    wpdc_lanes #(.DATA_W(DATA_W)) u_lanes (
        .size      (req_size),
        .offs      (r_off),
        .data      (req_data),
        .be        (lane_be),
        .lane_data (lane_data),
        .bad       (lane_bad)
    );

    wpdc_store #(
        .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_idx     (r_idx),
        .lk_tag     (r_tag),
        .lk_hit     (hit),
        .pr_idx     (probe_addr[WSEL_W +: IDX_W]),
        .pr_tag     (probe_addr[WADR_W-1 -: TAG_W]),
        .pr_word    (probe_addr[WSEL_W-1:0]),
        .pr_hit     (probe_hit),
        .pr_mod     (probe_mod),
        .pr_data    (probe_data),
        .wr_en      (upd_en),
        .wr_set_mod (upd_set_mod),
        .wr_idx     (r_idx),
        .wr_word    (r_word),
        .wr_be      (lane_be),
        .wr_data    (lane_data),
        .fill_en    (fill_valid),
        .fill_idx   (fill_line_addr[IDX_W-1:0]),
        .fill_tag   (fill_line_addr[LINE_W-1 -: TAG_W]),
        .fill_data  (fill_data)
    );

    wpdc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .fill_busy (fill_valid),
        .bad       (lane_bad),
        .hit       (hit),
        .copyback  (req_copyback),
        .mem_ack   (mem_ack),
        .upd_en    (upd_en),
        .set_mod   (upd_set_mod),
        .load_mem  (load_mem),
        .req_done  (req_done),
        .req_err   (req_err),
        .mem_req   (mem_req)
    );

    // Capture the outgoing memory write when a store is sent to memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr_q <= '0;
            mem_be_q   <= '0;
            mem_data_q <= '0;
        end else if (load_mem) begin
            mem_addr_q <= req_addr;
            mem_be_q   <= lane_be;
            mem_data_q <= lane_data;
        end
    end

    // Drive the memory and array-update outputs.
    always_comb begin
        mem_addr  = mem_addr_q;
        mem_be    = mem_be_q;
        mem_data  = mem_data_q;
        upd_index = r_idx;
        upd_word  = r_word;
        upd_be    = lane_be;
        upd_data  = lane_data;
    end
endmodule

// File: rtl/wpdc_ctrl_chk.sv
// Module: wpdc_ctrl_chk
// Temporal checks on the controller's ports, attached by bind.
module wpdc_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_done,
    input logic              req_err,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTES-1:0]  mem_be,
    input logic [DATA_W-1:0] mem_data,
    input logic              mem_ack,
    input logic              fill_valid,
    input logic              upd_en,
    input logic [BYTES-1:0]  upd_be,
    input logic              upd_set_mod
);
    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_data));
    // R2
    ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |-> req_done && !req_err);
    // R2
    wt_goes_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !upd_set_mod |=> mem_req);
    // R4
    cb_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_set_mod |-> upd_en && req_done && !mem_req);
    // R4
    cb_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_set_mod |=> !mem_req);
    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_done && !upd_en && !mem_req);
    // R7
    err_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !mem_req);
    // R8
    fill_defers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !mem_req |-> !req_done && !upd_en);
    // R10
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req && !req_valid |-> !req_done);
    // R1
    upd_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> upd_be != '0 && req_valid);
endmodule

bind wpdc_ctrl wpdc_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/wpdc_ctrl_bench.sv
module wpdc_ctrl_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_size = '0;
    logic [31:0]  req_data = '0;
    logic         req_copyback = 1'b0;
    logic         req_done, req_err, mem_req;
    logic [31:0]  mem_addr;
    logic [3:0]   mem_be;
    logic [31:0]  mem_data;
    logic         mem_ack = 1'b0;
    logic         fill_valid = 1'b0;
    logic [27:0]  fill_line_addr = '0;
    logic [127:0] fill_data = '0;
    logic [29:0]  probe_addr = '0;
    logic         probe_hit, probe_mod;
    logic [31:0]  probe_data;
    logic         upd_en, upd_set_mod;
    logic [3:0]   upd_index;
    logic [1:0]   upd_word;
    logic [3:0]   upd_be;
    logic [31:0]  upd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // behavioural model of the line storage
    bit          m_v   [16];
    bit          m_m   [16];
    logic [23:0] m_tag [16];
    logic [31:0] m_dat [16][4];
    logic [31:0] sent_q [$];

    always #10 clk = ~clk;

    wpdc_ctrl u_wpdc_ctrl (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_hit(input logic [31:0] a);
        return m_v[a[7:4]] && (m_tag[a[7:4]] == a[31:8]);
    endfunction

    // every clock: probe port against the model (R11)
    always @(posedge clk) begin
        #5;
        if (rst_n && !finished) begin
            logic [31:0] a;
            a = {probe_addr, 2'b00};
            chk(probe_hit == m_hit(a), "R11", "probe_hit", probe_hit, m_hit(a));
            if (m_hit(a)) begin
                chk(probe_mod == m_m[a[7:4]], "R11", "probe_mod", probe_mod, m_m[a[7:4]]);
                chk(probe_data == m_dat[a[7:4]][a[3:2]], "R11", "probe_data",
                    probe_data, m_dat[a[7:4]][a[3:2]]);
            end
        end
    end

    task automatic model_fill(input logic [31:0] a, input logic [127:0] d);
        m_v[a[7:4]] = 1'b1;
        m_m[a[7:4]] = 1'b0;
        m_tag[a[7:4]] = a[31:8];
        for (int w = 0; w < 4; w++) m_dat[a[7:4]][w] = d[w*32 +: 32];
    endtask

    task automatic do_fill(input logic [31:0] a, input logic [127:0] d);
        fill_valid = 1'b1;
        fill_line_addr = a[31:4];
        fill_data = d;
        @(posedge clk);
        model_fill(a, d);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // one store, started right after a negedge, ends right after a negedge
    task automatic do_wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d,
                         input bit cb, input int dly, input string tag);
        int nb, off;
        bit bad, hit;
        logic [3:0] be;
        logic [31:0] lane;
        off = int'(a[1:0]);
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
        bad = (nb == 0) || ((off % ((nb == 0) ? 1 : nb)) != 0);
        for (int b = 0; b < 4; b++) be[b] = !bad && (b >= off) && (b < off + nb);
        lane = d << (8 * off);
        hit = m_hit(a);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_data = d; req_copyback = cb;
        probe_addr = a[31:2];
        #1;
        if (bad) begin
            chk(req_done && req_err, tag, "error completion", {req_done, req_err}, 2'b11);
            chk(!upd_en, tag, "no update on error", upd_en, 0);
            @(posedge clk); @(negedge clk);
            req_valid = 1'b0;
            #1 chk(!mem_req, tag, "no memory write on error", mem_req, 0);
            return;
        end
        if (hit && cb) begin
            chk(req_done && !req_err && upd_en && upd_set_mod && !mem_req, tag,
                "copyback completes at once", {req_done, req_err, upd_en, upd_set_mod, mem_req}, 5'b10110);
            chk(upd_be == be, tag, "update lanes", upd_be, be);
            @(posedge clk);
            for (int b = 0; b < 4; b++) if (be[b]) m_dat[a[7:4]][a[3:2]][b*8 +: 8] = lane[b*8 +: 8];
            m_m[a[7:4]] = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            #1 chk(!mem_req, tag, "no memory write on copyback", mem_req, 0);
            return;
        end
        chk(!req_done && (upd_en == hit), tag, "stall and update", {req_done, upd_en}, {1'b0, hit});
        @(posedge clk);
        if (hit) for (int b = 0; b < 4; b++) if (be[b]) m_dat[a[7:4]][a[3:2]][b*8 +: 8] = lane[b*8 +: 8];
        @(negedge clk);
        chk(mem_req && mem_addr == a && mem_be == be && mem_data == lane, tag, "memory write fields",
            {mem_req, mem_addr, mem_be, mem_data}, {1'b1, a, be, lane});
        for (int i = 0; i < dly; i++) begin
            @(posedge clk); @(negedge clk);
            chk(mem_req && !req_done && mem_data == lane, tag, "held until ack",
                {mem_req, req_done}, 2'b10);
        end
        mem_ack = 1'b1;
        #1 chk(req_done && !req_err, tag, "done on ack", {req_done, req_err}, 2'b10);
        sent_q.push_back(a);
        @(posedge clk); @(negedge clk);
        mem_ack = 1'b0; req_valid = 1'b0;
        #1 chk(!mem_req, tag, "request released", mem_req, 0);
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_m[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        // R9 reset state
        chk(!mem_req && !req_done && !req_err, "R9", "reset outputs", {mem_req, req_done, req_err}, 0);
        chk(!probe_hit, "R9", "no valid line", probe_hit, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!probe_hit, "R9", "no valid line after release", probe_hit, 0);

        do_fill(32'h1000_0010, 128'h4444_4444_3333_3333_2222_2222_1111_1111);
        probe_addr = 30'h0400_0005;
        @(negedge clk);
        chk(probe_hit && !probe_mod, "R8", "install valid, clean", {probe_hit, probe_mod}, 2'b10);

        // write-through hits of each size (R1 R2 R3)
        do_wr(32'h1000_0016, 2'd0, 32'h0000_00AB, 1'b0, 2, "R1");
        chk(probe_data == 32'h22AB_2222, "R1", "byte merge", probe_data, 32'h22AB_2222);
        chk(!probe_mod, "R3", "wt keeps clean", probe_mod, 0);
        do_wr(32'h1000_001A, 2'd1, 32'h0000_BEEF, 1'b0, 0, "R2");
        chk(probe_data == 32'hBEEF_3333, "R1", "half merge", probe_data, 32'hBEEF_3333);
        do_wr(32'h1000_001C, 2'd2, 32'hCAFE_F00D, 1'b0, 3, "R2");

        // copyback hits (R4 R5)
        do_wr(32'h1000_0011, 2'd0, 32'h0000_0077, 1'b1, 0, "R4");
        chk(probe_mod && probe_data == 32'h1111_7711, "R4", "cb merge and modified",
            {probe_mod, probe_data}, {1'b1, 32'h1111_7711});
        do_wr(32'h1000_0010, 2'd1, 32'h0000_5A5A, 1'b1, 0, "R5");
        chk(probe_mod && probe_data == 32'h1111_5A5A, "R5", "stays modified",
            {probe_mod, probe_data}, {1'b1, 32'h1111_5A5A});
        // write-through on a modified line (R3)
        do_wr(32'h1000_0014, 2'd2, 32'h0102_0304, 1'b0, 1, "R3");
        chk(probe_mod, "R3", "wt keeps modified", probe_mod, 1);

        // misaligned and reserved (R7)
        do_wr(32'h1000_0011, 2'd1, 32'h0000_1234, 1'b1, 0, "R7");
        do_wr(32'h1000_0012, 2'd2, 32'h1234_5678, 1'b0, 0, "R7");
        do_wr(32'h1000_0010, 2'd3, 32'h1234_5678, 1'b1, 0, "R7");

        // misses in both regions (R6)
        do_wr(32'h2000_0014, 2'd2, 32'hDEAD_BEEF, 1'b0, 1, "R6");
        chk(!probe_hit, "R6", "no allocation", probe_hit, 0);
        do_wr(32'h3000_0019, 2'd0, 32'h0000_0099, 1'b1, 0, "R6");
        chk(!probe_hit, "R6", "no allocation copyback", probe_hit, 0);
        probe_addr = 30'h0400_0005;
        @(negedge clk);
        chk(probe_data == 32'h0102_0304 && probe_mod, "R6", "resident line intact",
            {probe_mod, probe_data}, {1'b1, 32'h0102_0304});
        chk(sent_q.size() == 6, "R6", "memory writes issued", sent_q.size(), 6);

        // stray acknowledge (R10)
        mem_ack = 1'b1;
        #1 chk(!req_done && !mem_req, "R10", "stray ack ignored", {req_done, mem_req}, 0);
        @(posedge clk); @(negedge clk);
        mem_ack = 1'b0;
        #1 chk(!req_done && probe_data == 32'h0102_0304, "R10", "state after stray ack",
               probe_data, 32'h0102_0304);

        // install and store in the same cycle, same line (R8)
        @(negedge clk);
        fill_valid = 1'b1;
        fill_line_addr = 28'h100_0001;
        fill_data = 128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_AAAA_AAAA;
        req_valid = 1'b1; req_addr = 32'h1000_0018; req_size = 2'd0;
        req_data = 32'h0000_0011; req_copyback = 1'b1;
        probe_addr = 30'h0400_0006;
        #1 chk(!req_done && !upd_en, "R8", "store deferred by fill", {req_done, upd_en}, 0);
        @(posedge clk);
        model_fill(32'h1000_0010, 128'hDDDD_DDDD_CCCC_CCCC_BBBB_BBBB_AAAA_AAAA);
        @(negedge clk);
        fill_valid = 1'b0;
        do_wr(32'h1000_0018, 2'd0, 32'h0000_0011, 1'b1, 0, "R8");
        chk(probe_data == 32'hCCCC_CC11 && probe_mod, "R8", "merge over fresh fill",
            {probe_mod, probe_data}, {1'b1, 32'hCCCC_CC11});
        probe_addr = 30'h0400_0004;
        @(negedge clk);
        chk(probe_data == 32'hAAAA_AAAA, "R8", "fill replaced old word", probe_data, 32'hAAAA_AAAA);

        @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule